// File: doc/BRIEF.md
# Serial-Programmed Frequency Word Loader

This block is the programming front end of a frequency synthesiser. A host writes words over a three-wire serial link made of data, clock and enable. Each word is 24 bits long and is sent most significant bit first. The block oversamples the three pins with its own system clock. While enable is high, it shifts one bit in on each rising edge of the serial clock. When enable falls, it checks the number of bits received. If the count is right, it copies the 22-bit payload into one of four holding buffers. The two bits received last pick the buffer.

There are two buffers for frequency words, one for the reference word and a small 4-bit buffer. An external select input decides which frequency word drives the divider outputs. Those outputs are registered, so the divider samples them at a clean boundary. The synthesiser can stay locked on one frequency word while the host rewrites the other. Toggling the select input then hops between the two. The buffers keep their contents while a new word is being shifted in.

Top module: `ser_loader_top`

## Requirements
- R1: After reset, all four buffers and every output are zero.
- R2: Serial bits are shifted on rising serial-clock edges while enable is high, first bit received ending up as bit 23. The word is acted on at the falling edge of enable. Bits 23..2 form the payload, and the last two bits received, C2 then C1, form the destination code.
- R3: The destination code {C2,C1} selects one buffer: 00 reference, 01 frequency word one, 10 frequency word two, 11 the 4-bit buffer. Only that buffer changes. The 4-bit buffer takes payload bits 3..0 and drives `a_buf`.
- R4: A frequency word is the whole 22-bit payload. Bits 21..7 form the main count (`div_m`) and bits 6..3 the swallow count (`div_a`). Bits 2..1 form the gain pair (`pd_gain`, bit 2 as its MSB) and bit 0 the sense bit.
- R5: The reference word is payload bits 15..0. Bits 15..3 form `ref_ratio`, bits 2..1 form `pd_enable` and bit 0 forms `pre_range`. Payload bits 21..16 are ignored.
- R6: When `f1_sel` is high, the divider outputs show frequency word one, and when it is low they show word two. The outputs follow a change of `f1_sel` one clock later.
- R7: Loading the frequency word that is not selected leaves the divider outputs unchanged.
- R8: Serial-clock edges received while enable is low neither shift nor count.
- R9: A word whose bit count is not exactly 24, whether shorter or longer, is discarded and leaves all buffers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Serial enable; a word is taken on its falling edge |
| f1_sel | input | 1 | High selects frequency word one, low selects word two |
| div_m | output | 15 | Main count of the selected word |
| div_a | output | 4 | Swallow count of the selected word |
| pd_gain | output | 2 | Gain pair of the selected word |
| pd_sense | output | 1 | Sense bit of the selected word |
| ref_ratio | output | 13 | Reference divide ratio |
| pd_enable | output | 2 | Phase-detector enable bits |
| pre_range | output | 1 | Prescaler range bit |
| a_buf | output | 4 | Contents of the 4-bit buffer |

## Verification
The bench builds the block with its default of two synchroniser stages on each serial pin. With that setting, each serial level needs to be held for only three system clocks. This lets the bench run many complete 24-bit words and also frames of 23 and 25 bits in a short run. The two-stage path still covers the delay from pin to buffer, so holding the inactive word and re-timing the select change one clock later can both be observed at the ports.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int SR_W   = 24;
    localparam int CODE_W = 2;
    localparam int PAY_W  = SR_W - CODE_W;
    localparam int REF_W  = 16;
    localparam int AB_W   = 4;

    typedef enum logic [CODE_W-1:0] {
        DST_REF  = 2'b00,
        DST_F1   = 2'b01,
        DST_F2   = 2'b10,
        DST_ABUF = 2'b11
    } dest_e;

    typedef struct packed {
        logic [14:0] m;
        logic [3:0]  a;
        logic [1:0]  gain;
        logic        sense;
    } fword_t;

    typedef struct packed {
        logic [12:0] ratio;
        logic [1:0]  pd_en;
        logic        pre;
    } rword_t;

endpackage

// File: rtl/slp_pin_sync.sv
module slp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic sdata_pin,
    input  logic sen_pin,
    output logic sclk_rise,
    output logic sen_fall,
    output logic en_lvl,
    output logic data_lvl
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sclk_s;
        logic [STAGES-1:0] data_s;
        logic [STAGES-1:0] en_s;
        logic              sclk_prev;
        logic              en_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_s    = {st_q.sclk_s[STAGES-2:0], sclk_pin};
        st_d.data_s    = {st_q.data_s[STAGES-2:0], sdata_pin};
        st_d.en_s      = {st_q.en_s[STAGES-2:0], sen_pin};
        st_d.sclk_prev = st_q.sclk_s[LAST];
        st_d.en_prev   = st_q.en_s[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_rise = st_q.sclk_s[LAST] & ~st_q.sclk_prev;
    assign sen_fall  = ~st_q.en_s[LAST] & st_q.en_prev;
    assign en_lvl    = st_q.en_s[LAST];
    assign data_lvl  = st_q.data_s[LAST];

endmodule

// File: rtl/slp_shifter.sv
module slp_shifter
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sen_fall,
    input  logic              en_lvl,
    input  logic              data_lvl,
    output logic              xfer_vld,
    output dest_e             xfer_dest,
    output logic [PAY_W-1:0]  xfer_pay
);

    localparam int CNT_W = $clog2(SR_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SR_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SR_W + 1);

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        dest_e            dest;
        logic [PAY_W-1:0] pay;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (sen_fall) begin
            s_d.vld  = (s_q.cnt == CNT_FULL);
            s_d.dest = dest_e'(s_q.sr[CODE_W-1:0]);
            s_d.pay  = s_q.sr[SR_W-1:CODE_W];
            s_d.cnt  = '0;
        end else if (en_lvl && sclk_rise) begin
            s_d.sr = {s_q.sr[SR_W-2:0], data_lvl};
            if (s_q.cnt != CNT_SAT) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign xfer_vld  = s_q.vld;
    assign xfer_dest = s_q.dest;
    assign xfer_pay  = s_q.pay;

endmodule

// File: rtl/slp_buffers.sv
module slp_buffers
    import slp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_vld,
    input  dest_e            xfer_dest,
    input  logic [PAY_W-1:0] xfer_pay,
    input  logic             f1_sel,
    output fword_t           f1_word,
    output fword_t           f2_word,
    output rword_t           ref_word,
    output logic [AB_W-1:0]  ab_word,
    output fword_t           act_word
);

    typedef struct packed {
        fword_t          f1;
        fword_t          f2;
        rword_t          rw;
        logic [AB_W-1:0] ab;
        fword_t          act;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (xfer_vld) begin
            case (xfer_dest)
                DST_REF:  b_d.rw = rword_t'(xfer_pay[REF_W-1:0]);
                DST_F1:   b_d.f1 = fword_t'(xfer_pay);
                DST_F2:   b_d.f2 = fword_t'(xfer_pay);
                default:  b_d.ab = xfer_pay[AB_W-1:0];
            endcase
        end
        b_d.act = f1_sel ? b_q.f1 : b_q.f2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign f1_word  = b_q.f1;
    assign f2_word  = b_q.f2;
    assign ref_word = b_q.rw;
    assign ab_word  = b_q.ab;
    assign act_word = b_q.act;

endmodule

// File: rtl/ser_loader_top.sv
module ser_loader_top
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_en,
    input  logic        f1_sel,
    output logic [14:0] div_m,
    output logic [3:0]  div_a,
    output logic [1:0]  pd_gain,
    output logic        pd_sense,
    output logic [12:0] ref_ratio,
    output logic [1:0]  pd_enable,
    output logic        pre_range,
    output logic [3:0]  a_buf
);

    logic             sclk_rise, sen_fall, en_lvl, data_lvl;
    logic             xfer_vld;
    dest_e            xfer_dest;
    logic [PAY_W-1:0] xfer_pay;
    fword_t           f1_word, f2_word, act_word;
    rword_t           ref_word;
    logic [AB_W-1:0]  ab_word;

    slp_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (ser_clk),
        .sdata_pin (ser_data),
        .sen_pin   (ser_en),
        .sclk_rise (sclk_rise),
        .sen_fall  (sen_fall),
        .en_lvl    (en_lvl),
        .data_lvl  (data_lvl)
    );

    slp_shifter shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sen_fall  (sen_fall),
        .en_lvl    (en_lvl),
        .data_lvl  (data_lvl),
        .xfer_vld  (xfer_vld),
        .xfer_dest (xfer_dest),
        .xfer_pay  (xfer_pay)
    );

    slp_buffers buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_vld  (xfer_vld),
        .xfer_dest (xfer_dest),
        .xfer_pay  (xfer_pay),
        .f1_sel    (f1_sel),
        .f1_word   (f1_word),
        .f2_word   (f2_word),
        .ref_word  (ref_word),
        .ab_word   (ab_word),
        .act_word  (act_word)
    );

    assign div_m     = act_word.m;
    assign div_a     = act_word.a;
    assign pd_gain   = act_word.gain;
    assign pd_sense  = act_word.sense;
    assign ref_ratio = ref_word.ratio;
    assign pd_enable = ref_word.pd_en;
    assign pre_range = ref_word.pre;
    assign a_buf     = ab_word;

endmodule

// File: rtl/slp_checker.sv
module slp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_vld,
    input logic [1:0]  xfer_dest,
    input logic [21:0] xfer_pay,
    input logic        en_lvl,
    input logic        f1_sel,
    input logic [21:0] f1_word,
    input logic [21:0] f2_word,
    input logic [14:0] div_m,
    input logic [3:0]  div_a,
    input logic [1:0]  pd_gain,
    input logic        pd_sense,
    input logic [12:0] ref_ratio,
    input logic [1:0]  pd_enable,
    input logic        pre_range,
    input logic [3:0]  a_buf
);

    // R2: a word is only taken once enable has gone low
    a_r2_xfer_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_vld |-> !en_lvl);

    // R3: the 4-bit buffer takes the low payload nibble
    a_r3_abuf_load: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && xfer_dest == 2'b11) |=> a_buf == $past(xfer_pay[3:0]));

    // R5: reference fields come from payload bits 15..0
    a_r5_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && xfer_dest == 2'b00) |=>
            {ref_ratio, pd_enable, pre_range} == $past(xfer_pay[15:0]));

    // R3: the reference buffer holds unless it is addressed
    a_r3_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_vld && xfer_dest == 2'b00) |=>
            $stable({ref_ratio, pd_enable, pre_range}));

    // R6: select high shows word one one clock later
    a_r6_sel_f1: assert property (@(posedge clk) disable iff (!rst_n)
        f1_sel |=> {div_m, div_a, pd_gain, pd_sense} == $past(f1_word));

    // R6: select low shows word two one clock later
    a_r6_sel_f2: assert property (@(posedge clk) disable iff (!rst_n)
        !f1_sel |=> {div_m, div_a, pd_gain, pd_sense} == $past(f2_word));

endmodule

bind ser_loader_top slp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_vld  (xfer_vld),
    .xfer_dest (xfer_dest),
    .xfer_pay  (xfer_pay),
    .en_lvl    (en_lvl),
    .f1_sel    (f1_sel),
    .f1_word   (f1_word),
    .f2_word   (f2_word),
    .div_m     (div_m),
    .div_a     (div_a),
    .pd_gain   (pd_gain),
    .pd_sense  (pd_sense),
    .ref_ratio (ref_ratio),
    .pd_enable (pd_enable),
    .pre_range (pre_range),
    .a_buf     (a_buf)
);

// File: tb/ser_loader_top_tb_top.sv
module ser_loader_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_en = 1'b0;
    logic        f1_sel = 1'b1;
    logic [14:0] div_m;
    logic [3:0]  div_a;
    logic [1:0]  pd_gain;
    logic        pd_sense;
    logic [12:0] ref_ratio;
    logic [1:0]  pd_enable;
    logic        pre_range;
    logic [3:0]  a_buf;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    ser_loader_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .f1_sel(f1_sel), .div_m(div_m), .div_a(div_a),
        .pd_gain(pd_gain), .pd_sense(pd_sense), .ref_ratio(ref_ratio),
        .pd_enable(pd_enable), .pre_range(pre_range), .a_buf(a_buf)
    );

    typedef struct packed {
        logic [23:0] frame;
        logic        sel;
        logic [21:0] exp_f;
        logic [15:0] exp_ref;
        logic [3:0]  exp_ab;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{{15'h1234, 4'h5, 3'b101, 2'b01}, 1'b1, {15'h1234, 4'h5, 3'b101}, 16'h0000, 4'h0},
        '{{15'h7ABC, 4'hA, 3'b010, 2'b10}, 1'b1, {15'h1234, 4'h5, 3'b101}, 16'h0000, 4'h0},
        '{{6'h3F, 16'hBEEF, 2'b00},        1'b0, {15'h7ABC, 4'hA, 3'b010}, 16'hBEEF, 4'h0},
        '{{18'h0, 4'h9, 2'b11},            1'b0, {15'h7ABC, 4'hA, 3'b010}, 16'hBEEF, 4'h9},
        '{{15'h0001, 4'hF, 3'b000, 2'b01}, 1'b0, {15'h7ABC, 4'hA, 3'b010}, 16'hBEEF, 4'h9},
        '{{15'h4000, 4'h0, 3'b111, 2'b10}, 1'b1, {15'h0001, 4'hF, 3'b000}, 16'hBEEF, 4'h9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(3);
        ser_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_bits(input logic [24:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
    endtask

    task automatic send_frame(input logic [24:0] bits, input int n);
        ser_en = 1'b1;
        wait_clk(3);
        send_bits(bits, n);
        ser_en = 1'b0;
        wait_clk(10);
    endtask

    function automatic logic [31:0] fout();
        return {10'd0, div_m, div_a, pd_gain, pd_sense};
    endfunction

    function automatic logic [31:0] rout();
        return {16'd0, ref_ratio, pd_enable, pre_range};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        check("R1 freq outputs", fout(), 32'd0);
        check("R1 ref outputs", rout(), 32'd0);
        check("R1 a_buf", {28'd0, a_buf}, 32'd0);

        // R2 R3 R4 R5 R6 R7: table of loads
        for (int v = 0; v < 6; v++) begin
            f1_sel = VECS[v].sel;
            send_frame({1'b0, VECS[v].frame}, 24);
            check("R4 R6 R7 selected word", fout(), {10'd0, VECS[v].exp_f});
            check("R5 R3 reference word", rout(), {16'd0, VECS[v].exp_ref});
            check("R3 a_buf", {28'd0, a_buf}, {28'd0, VECS[v].exp_ab});
        end

        // R6: select change shows up after one clock
        f1_sel = 1'b0;
        wait_clk(1);
        check("R6 select low word two", fout(), {10'd0, 15'h4000, 4'h0, 3'b111});
        f1_sel = 1'b1;
        wait_clk(1);
        check("R6 select high word one", fout(), {10'd0, 15'h0001, 4'hF, 3'b000});

        // R9: 23-bit word discarded
        send_frame({2'b0, 17'h0, 4'h3, 2'b11}, 23);
        check("R9 short word", {28'd0, a_buf}, 32'h9);
        // R9: 25-bit word discarded
        send_frame({1'b1, 18'h0, 4'h3, 2'b11}, 25);
        check("R9 long word", {28'd0, a_buf}, 32'h9);
        check("R9 long word ref", rout(), 32'hBEEF);

        // R8: clock pulses with enable low do not count
        ser_en = 1'b0;
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        send_frame({5'b0, 14'h0, 4'h3, 2'b11}, 20);
        check("R8 pulses ignored", {28'd0, a_buf}, 32'h9);

        // R2: a valid word still loads afterwards
        send_frame({1'b0, 18'h0, 4'h6, 2'b11}, 24);
        check("R2 reload after discard", {28'd0, a_buf}, 32'h6);
        check("R7 selected word kept", fout(), {10'd0, 15'h0001, 4'hF, 3'b000});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule